// File: doc/BRIEF.md
# Bus traffic performance counter

This block watches one bus port and counts its data traffic. It has four event counters and one free-running cycle counter. Each event counter is given an event code that selects what it counts: read data beats, write data beats, or both (the combined code works only on the last channel). Software starts a measurement by choosing the event codes, turning on the counters it wants and setting the global enable. It can clear the counters in the same write. To take a reading it clears the global enable, which freezes every counter so that all of them can be read back as one consistent snapshot.

A counter that wraps raises a sticky flag. Each flag can be routed to the interrupt output. The event inputs are per-cycle strobes that are already qualified by the read-data and write-data handshakes of the bus. The control register also holds a start-mode field. The field is stored and reads back, but counting always behaves as manual start.

Register access uses a single-cycle request port. A write takes effect at the clock edge on which it is presented. Read data is returned combinationally while a read is presented. When no read is presented the read data is zero.

Top module: `bus_perf_monitor`

## Requirements
- R1: After reset every register, every counter and the interrupt output read as zero.
- R2: Writing ones to offset 0x08 turns on the matching counters and writing ones to offset 0x0c turns them off. Bit n (n = 0..3) is event counter n and bit 31 is the cycle counter. Both offsets read back the current enable mask.
- R3: An event counter whose type register (offset 0x200 + 4*n, bits 7:0) holds 0x04 adds one for each cycle with a read beat. Code 0x05 adds one for each cycle with a write beat. Any other code, such as 0x00, counts nothing.
- R4: Code 0x22 on channel 3 counts read and write beats together and adds two when both arrive in one cycle. On channels 0 to 2, code 0x22 counts nothing.
- R5: Event counters 0, 1 and 2 are EVT_W bits wide and read at offsets 0x34, 0x38 and 0x3c. Event counter 3 is EVT_W+8 bits wide: its low EVT_W bits read at 0x40 and its upper 8 bits read in bits 7:0 of 0x44. The cycle counter reads at 0x48.
- R6: A counter advances only while the global enable (control offset 0x04, bit 0) and its own enable are both set. When the global enable is clear, every counter holds its value.
- R7: Control bit 1 clears all event counters and bit 2 clears the cycle counter and its prescaler. Each acts once, in the cycle it is written, and reads back as zero. If a write sets bit 0 together with a reset bit, counting starts from zero.
- R8: With control bit 3 clear, the cycle counter adds one on every enabled cycle. With bit 3 set, it adds one on every 64th enabled cycle after it was cleared.
- R9: When a counter wraps past its maximum, its flag bit is set in offset 0x18, using the same bit positions as R2. Writing one to a flag bit clears it, and a wrap in the same cycle wins over the clear.
- R10: Interrupt enables are set by writing ones to 0x10 and cleared by writing ones to 0x14, with the bit positions of R2. The irq output is high exactly when some flag has its interrupt enable set.
- R11: Control bits 21:20 (start mode: 0 manual, 1 automatic, 2 conditional) and bit 3 read back as written. Counting behaves the same whatever the start mode is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid while a read is presented |
| rd_beat | input | 1 | A read data beat was accepted this cycle |
| wr_beat | input | 1 | A write data beat was accepted this cycle |
| irq | output | 1 | Level interrupt from enabled flags |

## Verification
The main counting function is driven with random, independent read and write strobes. Under this traffic one cycle can hold a read only, a write only, both, or neither. This separates channels counting reads from channels counting writes, and it shows whether the combined channel adds two on a cycle with both beats. The same traffic is also sent to a channel given the combined code on a narrow slot, and to a channel that has been turned off. These show that such channels stay still. Traffic that continues after the global enable is cleared tells a real freeze apart from a counter that only stops on certain events. A run with the divider on and a non-manual start mode separates the 64-cycle prescale from plain cycle counting.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned MASK_W  = NUM_EVT + 1;

  localparam logic [11:0] A_CTRL    = 12'h004;
  localparam logic [11:0] A_EN_SET  = 12'h008;
  localparam logic [11:0] A_EN_CLR  = 12'h00c;
  localparam logic [11:0] A_IE_SET  = 12'h010;
  localparam logic [11:0] A_IE_CLR  = 12'h014;
  localparam logic [11:0] A_FLAG    = 12'h018;
  localparam logic [11:0] A_CNT0    = 12'h034;
  localparam logic [11:0] A_WIDE_LO = 12'h040;
  localparam logic [11:0] A_WIDE_HI = 12'h044;
  localparam logic [11:0] A_CYC     = 12'h048;
  localparam logic [11:0] A_TYPE0   = 12'h200;

  localparam logic [7:0] EV_RD = 8'h04;
  localparam logic [7:0] EV_WR = 8'h05;
  localparam logic [7:0] EV_RW = 8'h22;

  typedef enum logic [1:0] {
    START_MANUAL = 2'd0,
    START_AUTO   = 2'd1,
    START_COND   = 2'd2,
    START_RSVD   = 2'd3
  } start_mode_e;

  typedef struct packed {
    start_mode_e mode;
    logic        div;
    logic        en;
  } ctrl_t;

endpackage

// File: rtl/bpm_event_counter.sv
module bpm_event_counter
  import bpm_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter bit          ALLOW_BOTH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [7:0]       code_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [1:0]       step;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  generate
    if (ALLOW_BOTH) begin : g_both
      always_comb begin
        case (code_i)
          EV_RD:   step = {1'b0, rd_i};
          EV_WR:   step = {1'b0, wr_i};
          EV_RW:   step = {1'b0, rd_i} + {1'b0, wr_i};
          default: step = 2'd0;
        endcase
      end
    end else begin : g_single
      always_comb begin
        case (code_i)
          EV_RD:   step = {1'b0, rd_i};
          EV_WR:   step = {1'b0, wr_i};
          default: step = 2'd0;
        endcase
      end

      // R4
      narrow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
    end
  endgenerate

  always_comb begin
    sum    = {1'b0, cnt_q} + SUM_W'(step);
    cnt_we = clr_i | (run_i & (|step));
    cnt_d  = clr_i ? '0 : sum[CNT_W-1:0];
    wrap_o = run_i & ~clr_i & sum[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_o));

  // R7
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/bpm_cycle_counter.sv
module bpm_cycle_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             div_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [DIV_LOG2-1:0] pre_q, pre_d;
  logic                pre_we;
  logic                tick;
  logic [SUM_W-1:0]    sum;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                cnt_we;

  always_comb begin
    tick   = run_i & (~div_i | (&pre_q));
    pre_we = clr_i | run_i;
    pre_d  = clr_i ? '0 : pre_q + 1'b1;
    sum    = {1'b0, cnt_q} + SUM_W'(1);
    cnt_we = clr_i | tick;
    cnt_d  = clr_i ? '0 : sum[CNT_W-1:0];
    wrap_o = tick & ~clr_i & sum[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_we) pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i && !clr_i && !(&pre_q)) |=> $stable(cnt_o));

  // R6
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
  import bpm_pkg::*;
#(
  parameter int unsigned EVT_W = 32,
  parameter int unsigned HI_W  = 8,
  parameter int unsigned CYC_W = 32,
  localparam int unsigned WIDE_W = EVT_W + HI_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [11:0]                        req_addr,
  input  logic [31:0]                        req_wdata,
  output logic [31:0]                        rsp_rdata,
  output ctrl_t                              ctrl_o,
  output logic                               evt_clr_o,
  output logic                               cyc_clr_o,
  output logic [NUM_EVT-1:0]                 evt_en_o,
  output logic                               cyc_en_o,
  output logic [NUM_EVT-1:0][7:0]            evt_type_o,
  input  logic [NUM_EVT-1:0]                 evt_wrap_i,
  input  logic                               cyc_wrap_i,
  input  logic [NUM_EVT-2:0][EVT_W-1:0]      narrow_cnt_i,
  input  logic [WIDE_W-1:0]                  wide_cnt_i,
  input  logic [CYC_W-1:0]                   cyc_cnt_i,
  output logic                               irq_o
);

  function automatic logic [MASK_W-1:0] fold(input logic [31:0] w);
    return {w[31], w[NUM_EVT-1:0]};
  endfunction

  function automatic logic [31:0] unfold(input logic [MASK_W-1:0] m);
    logic [31:0] r;
    r = '0;
    r[NUM_EVT-1:0] = m[NUM_EVT-1:0];
    r[31] = m[MASK_W-1];
    return r;
  endfunction

  logic wr, rd;
  ctrl_t ctrl_q, ctrl_d;
  logic ctrl_we;
  logic [MASK_W-1:0] en_q, en_d, ie_q, ie_d, flag_q, flag_d, wmask, flag_clr;
  logic en_we, ie_we, flag_we;
  logic [NUM_EVT-1:0][7:0] type_q, type_d;
  logic [NUM_EVT-1:0] type_we;

  always_comb begin
    wr      = req_valid & req_write;
    rd      = req_valid & ~req_write;
    wmask   = fold(req_wdata);

    ctrl_we = wr && (req_addr == A_CTRL);
    ctrl_d.en   = req_wdata[0];
    ctrl_d.div  = req_wdata[3];
    ctrl_d.mode = start_mode_e'(req_wdata[21:20]);
    evt_clr_o = ctrl_we & req_wdata[1];
    cyc_clr_o = ctrl_we & req_wdata[2];

    en_d = en_q;
    if (wr && req_addr == A_EN_SET) en_d = en_q | wmask;
    if (wr && req_addr == A_EN_CLR) en_d = en_q & ~wmask;
    en_we = wr && (req_addr == A_EN_SET || req_addr == A_EN_CLR);

    ie_d = ie_q;
    if (wr && req_addr == A_IE_SET) ie_d = ie_q | wmask;
    if (wr && req_addr == A_IE_CLR) ie_d = ie_q & ~wmask;
    ie_we = wr && (req_addr == A_IE_SET || req_addr == A_IE_CLR);

    flag_clr = (wr && req_addr == A_FLAG) ? wmask : '0;
    flag_d   = (flag_q & ~flag_clr) | {cyc_wrap_i, evt_wrap_i};
    flag_we  = (|flag_clr) | cyc_wrap_i | (|evt_wrap_i);
  end

  generate
    for (genvar n = 0; n < NUM_EVT; n++) begin : g_type
      always_comb begin
        type_we[n] = wr && (req_addr == A_TYPE0 + 12'(4 * n));
        type_d[n]  = req_wdata[7:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          type_q[n] <= '0;
        else if (type_we[n]) type_q[n] <= type_d[n];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_we) ie_q <= ie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_d;
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd) begin
      if (req_addr == A_CTRL) begin
        rsp_rdata[0]     = ctrl_q.en;
        rsp_rdata[3]     = ctrl_q.div;
        rsp_rdata[21:20] = ctrl_q.mode;
      end
      if (req_addr == A_EN_SET || req_addr == A_EN_CLR) rsp_rdata = unfold(en_q);
      if (req_addr == A_IE_SET || req_addr == A_IE_CLR) rsp_rdata = unfold(ie_q);
      if (req_addr == A_FLAG)    rsp_rdata = unfold(flag_q);
      for (int n = 0; n < NUM_EVT - 1; n++)
        if (req_addr == A_CNT0 + 12'(4 * n)) rsp_rdata = 32'(narrow_cnt_i[n]);
      if (req_addr == A_WIDE_LO) rsp_rdata = 32'(wide_cnt_i[EVT_W-1:0]);
      if (req_addr == A_WIDE_HI) rsp_rdata = 32'(wide_cnt_i[WIDE_W-1:EVT_W]);
      if (req_addr == A_CYC)     rsp_rdata = 32'(cyc_cnt_i);
      for (int n = 0; n < NUM_EVT; n++)
        if (req_addr == A_TYPE0 + 12'(4 * n)) rsp_rdata = 32'(type_q[n]);
    end
  end

  assign ctrl_o     = ctrl_q;
  assign evt_en_o   = en_q[NUM_EVT-1:0];
  assign cyc_en_o   = en_q[MASK_W-1];
  assign evt_type_o = type_q;
  assign irq_o      = |(flag_q & ie_q);

  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_EN_CLR && req_wdata[0]) |=> !evt_en_o[0]);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wrap_i[NUM_EVT-1] |=> flag_q[NUM_EVT-1]);

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_IE_CLR && (&req_wdata)) |=> !irq_o);

endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor
  import bpm_pkg::*;
#(
  parameter int unsigned EVT_W    = 32,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned CYC_W    = 32,
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  input  logic        rd_beat,
  input  logic        wr_beat,
  output logic        irq
);

  localparam int unsigned WIDE_W = EVT_W + HI_W;

  ctrl_t                          ctrl;
  logic                           evt_clr, cyc_clr, cyc_en, cyc_wrap;
  logic [NUM_EVT-1:0]             evt_en, evt_wrap;
  logic [NUM_EVT-1:0][7:0]        evt_type;
  logic [NUM_EVT-2:0][EVT_W-1:0]  narrow_cnt;
  logic [WIDE_W-1:0]              wide_cnt;
  logic [CYC_W-1:0]               cyc_cnt;

  bpm_regs #(.EVT_W(EVT_W), .HI_W(HI_W), .CYC_W(CYC_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_rdata    (rsp_rdata),
    .ctrl_o       (ctrl),
    .evt_clr_o    (evt_clr),
    .cyc_clr_o    (cyc_clr),
    .evt_en_o     (evt_en),
    .cyc_en_o     (cyc_en),
    .evt_type_o   (evt_type),
    .evt_wrap_i   (evt_wrap),
    .cyc_wrap_i   (cyc_wrap),
    .narrow_cnt_i (narrow_cnt),
    .wide_cnt_i   (wide_cnt),
    .cyc_cnt_i    (cyc_cnt),
    .irq_o        (irq)
  );

  generate
    for (genvar n = 0; n < NUM_EVT; n++) begin : g_chan
      if (n == NUM_EVT - 1) begin : g_wide
        bpm_event_counter #(.CNT_W(WIDE_W), .ALLOW_BOTH(1'b1)) u_cnt (
          .clk    (clk),
          .rst_n  (rst_n),
          .run_i  (ctrl.en & evt_en[n]),
          .clr_i  (evt_clr),
          .code_i (evt_type[n]),
          .rd_i   (rd_beat),
          .wr_i   (wr_beat),
          .cnt_o  (wide_cnt),
          .wrap_o (evt_wrap[n])
        );
      end else begin : g_narrow
        bpm_event_counter #(.CNT_W(EVT_W), .ALLOW_BOTH(1'b0)) u_cnt (
          .clk    (clk),
          .rst_n  (rst_n),
          .run_i  (ctrl.en & evt_en[n]),
          .clr_i  (evt_clr),
          .code_i (evt_type[n]),
          .rd_i   (rd_beat),
          .wr_i   (wr_beat),
          .cnt_o  (narrow_cnt[n]),
          .wrap_o (evt_wrap[n])
        );
      end
    end
  endgenerate

  bpm_cycle_counter #(.CNT_W(CYC_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (ctrl.en & cyc_en),
    .div_i  (ctrl.div),
    .clr_i  (cyc_clr),
    .cnt_o  (cyc_cnt),
    .wrap_o (cyc_wrap)
  );

  // R1
  irq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

endmodule

// File: tb/sim_bus_perf_monitor.sv
`timescale 1ns/1ps
module sim_bus_perf_monitor;

  localparam int EW = 8;
  localparam int HW = 8;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, rd_beat, wr_beat, irq;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;

  always #10 clk = ~clk;

  bus_perf_monitor #(.EVT_W(EW), .HI_W(HW), .CYC_W(CW), .DIV_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rd_beat(rd_beat), .wr_beat(wr_beat), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit m_gen, m_div;
  bit [1:0] m_mode;
  bit [4:0] m_en, m_ie, m_flag;
  bit [7:0] m_type [4];
  longint unsigned m_cnt [4];
  longint unsigned m_cyc;
  int m_pre;

  function automatic longint unsigned cmask(int n);
    return (n < 3) ? ((64'd1 << EW) - 1) : ((64'd1 << (EW + HW)) - 1);
  endfunction

  function automatic bit [31:0] unf(bit [4:0] m);
    return {m[4], 27'b0, m[3:0]};
  endfunction

  function automatic bit [4:0] fld(bit [31:0] w);
    return {w[31], w[3:0]};
  endfunction

  function automatic bit [31:0] model_read(bit [11:0] a);
    bit [31:0] r = '0;
    case (a)
      12'h004: begin r[0] = m_gen; r[3] = m_div; r[21:20] = m_mode; end
      12'h008, 12'h00c: r = unf(m_en);
      12'h010, 12'h014: r = unf(m_ie);
      12'h018: r = unf(m_flag);
      12'h034: r = 32'(m_cnt[0]);
      12'h038: r = 32'(m_cnt[1]);
      12'h03c: r = 32'(m_cnt[2]);
      12'h040: r = 32'(m_cnt[3] & ((64'd1 << EW) - 1));
      12'h044: r = 32'(m_cnt[3] >> EW);
      12'h048: r = 32'(m_cyc);
      12'h200: r = 32'(m_type[0]);
      12'h204: r = 32'(m_type[1]);
      12'h208: r = 32'(m_type[2]);
      12'h20c: r = 32'(m_type[3]);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_tick(bit v, bit w, bit [11:0] a, bit [31:0] d, bit rb, bit wb);
    bit wr = v & w;
    bit ev_clr = wr && a == 12'h004 && d[1];
    bit cy_clr = wr && a == 12'h004 && d[2];
    bit [4:0] wraps = '0;
    for (int n = 0; n < 4; n++) begin
      int stp = 0;
      if (m_type[n] == 8'h04) stp = int'(rb);
      else if (m_type[n] == 8'h05) stp = int'(wb);
      else if (m_type[n] == 8'h22 && n == 3) stp = int'(rb) + int'(wb);
      if (ev_clr) m_cnt[n] = 0;
      else if (m_gen && m_en[n]) begin
        longint unsigned s = m_cnt[n] + longint'(stp);
        if (s > cmask(n)) wraps[n] = 1'b1;
        m_cnt[n] = s & cmask(n);
      end
    end
    if (cy_clr) begin m_cyc = 0; m_pre = 0; end
    else if (m_gen && m_en[4]) begin
      bit tick = !m_div || m_pre == 63;
      m_pre = (m_pre + 1) % 64;
      if (tick) begin
        if (m_cyc == (64'd1 << CW) - 1) begin wraps[4] = 1'b1; m_cyc = 0; end
        else m_cyc = m_cyc + 1;
      end
    end
    if (wr) begin
      case (a)
        12'h004: begin m_gen = d[0]; m_div = d[3]; m_mode = d[21:20]; end
        12'h008: m_en = m_en | fld(d);
        12'h00c: m_en = m_en & ~fld(d);
        12'h010: m_ie = m_ie | fld(d);
        12'h014: m_ie = m_ie & ~fld(d);
        12'h200: m_type[0] = d[7:0];
        12'h204: m_type[1] = d[7:0];
        12'h208: m_type[2] = d[7:0];
        12'h20c: m_type[3] = d[7:0];
        default: ;
      endcase
    end
    m_flag = (m_flag & ~((wr && a == 12'h018) ? fld(d) : 5'b0)) | wraps;
  endtask

  task automatic do_cycle(bit v, bit w, bit [11:0] a, bit [31:0] d, bit rb, bit wb);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rd_beat = rb; wr_beat = wb;
    model_tick(v, w, a, d, rb, wb);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; rd_beat = 1'b0; wr_beat = 1'b0;
  endtask

  task automatic reg_wr(bit [11:0] a, bit [31:0] d);
    do_cycle(1'b1, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic chk(string tag, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, bit [11:0] a);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    chk(tag, rsp_rdata, model_read(a));
    do_cycle(1'b1, 1'b0, a, '0, 1'b0, 1'b0);
  endtask

  task automatic irq_chk(string tag);
    chk(tag, 32'(irq), 32'(|(m_flag & m_ie)));
  endtask

  task automatic traffic(int n);
    for (int i = 0; i < n; i++)
      do_cycle(1'b0, 1'b0, '0, '0, 1'($urandom % 2), 1'($urandom % 2));
  endtask

  task automatic read_all(string tag);
    rd_chk({tag, " cnt0"}, 12'h034);
    rd_chk({tag, " cnt1"}, 12'h038);
    rd_chk({tag, " cnt2"}, 12'h03c);
    rd_chk({tag, " cnt3 low"}, 12'h040);
    rd_chk({tag, " cnt3 high"}, 12'h044);
    rd_chk({tag, " cycles"}, 12'h048);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; rd_beat = 0; wr_beat = 0;
    m_gen = 0; m_div = 0; m_mode = 0; m_en = 0; m_ie = 0; m_flag = 0;
    m_cyc = 0; m_pre = 0;
    for (int n = 0; n < 4; n++) begin m_type[n] = 0; m_cnt[n] = 0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 12'h004);
    rd_chk("R1 enables", 12'h008);
    rd_chk("R1 flags", 12'h018);
    read_all("R1");
    irq_chk("R1 irq");

    // R3 R4 event codes
    reg_wr(12'h200, 32'h04);
    reg_wr(12'h204, 32'h05);
    reg_wr(12'h208, 32'h22);
    reg_wr(12'h20c, 32'h22);
    rd_chk("R3 type readback", 12'h204);
    // R2 enable set
    reg_wr(12'h008, 32'h8000_000f);
    rd_chk("R2 enable set", 12'h00c);
    // R7 enable plus reset in one write
    reg_wr(12'h004, 32'h0000_0007);
    rd_chk("R7 reset bits read zero", 12'h004);
    traffic(300);
    reg_wr(12'h004, 32'h0);
    // R3 R4 R5 R8 snapshot
    read_all("R3 R4 R5 R8 run1");
    // R9 flags after wraps
    rd_chk("R9 flags set", 12'h018);
    irq_chk("R10 irq masked");
    // R10 irq enable
    reg_wr(12'h010, 32'h0000_0001);
    irq_chk("R10 irq on");
    rd_chk("R10 ie readback", 12'h014);
    // R9 write-one clear
    reg_wr(12'h018, 32'h0000_0001);
    rd_chk("R9 flag clear", 12'h018);
    irq_chk("R10 irq after clear");
    reg_wr(12'h014, 32'hffff_ffff);
    irq_chk("R10 ie clear");

    // R6 frozen while globally disabled
    traffic(40);
    read_all("R6 hold");

    // R2 clear channel 1 enable, R3 other code on ch2
    reg_wr(12'h00c, 32'h0000_0002);
    reg_wr(12'h208, 32'h00);
    rd_chk("R2 enable clear", 12'h008);
    // R11 R8 divider with a non-manual mode, no reset: counts continue
    reg_wr(12'h004, 32'h0020_0009);
    rd_chk("R11 mode readback", 12'h004);
    traffic(500);
    reg_wr(12'h004, 32'h0020_0008);
    read_all("R2 R8 R11 run2");

    // R7 cycle reset only; R8 divider from cleared prescaler
    reg_wr(12'h004, 32'h0000_000d);
    traffic(200);
    reg_wr(12'h004, 32'h0);
    read_all("R7 R8 run3");

    // R4 both strobes every cycle on combined channel
    reg_wr(12'h008, 32'h0000_000f);
    reg_wr(12'h004, 32'h0000_0003);
    for (int i = 0; i < 50; i++) do_cycle(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
    reg_wr(12'h004, 32'h0);
    read_all("R4 dual beats");
    rd_chk("R9 flags final", 12'h018);

    // mixed random register traffic and events
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 8;
      if (sel == 0) reg_wr(12'h008, $urandom);
      else if (sel == 1) reg_wr(12'h00c, $urandom);
      else if (sel == 2) reg_wr(12'h010, $urandom);
      else if (sel == 3) reg_wr(12'h018, $urandom);
      else if (sel == 4) reg_wr(12'h004, $urandom & 32'h0030_000f);
      else do_cycle(1'b0, 1'b0, '0, '0, 1'($urandom % 2), 1'($urandom % 2));
      irq_chk("R10 random irq");
    end
    reg_wr(12'h004, 32'h0);
    read_all("R6 random end");
    rd_chk("R9 random flags", 12'h018);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule